// File: doc/BRIEF.md
# Dual-Style Parallel Host Bus Front End

This block sits between a host processor's parallel bus and a character display command core. The host moves 8-bit instructions and display data across the bus, and the block turns each completed bus cycle into a one-clock transfer record for the core. Each record carries the register-select flag, the byte and a read/write indication. During a read the block drives the core's read byte back onto the bus.

A static strap picks one of two strobe conventions on the same two control pins. In enable style, one pin carries a read/write level and the other carries an active-high enable strobe. In split style, the two pins are active-low write and read strobes. All bus pins pass through synchronizers into the system clock. Every transfer completes on the trailing edge of its strobe.

The core supplies a width bit. When it is set, each strobe moves a whole byte. When it is clear, each strobe moves one nibble on the upper four data lines, high nibble first. The block reassembles the two nibbles into one record. An active-low external reset input holds the front end idle and is passed on to the core.

The phase machine has three states:
- `ST_HOLD`: external reset active.
- `ST_HI`: expecting a whole byte or a high nibble.
- `ST_LO`: expecting a low nibble.

Its transitions are:
- hold-enter: any state goes to `ST_HOLD` while the external reset is low.
- hold-exit: `ST_HOLD` goes to `ST_HI` once the external reset is released.
- nibble-split: `ST_HI` goes to `ST_LO` on a transfer in 4-bit width.
- nibble-join: `ST_LO` goes to `ST_HI` on the next transfer.
- width-clear: `ST_LO` goes to `ST_HI` when the width bit changes.
- byte-stay: `ST_HI` stays in `ST_HI` on a transfer in 8-bit width.

Top module: `hostif_pbus`

## Requirements
- R1: After reset the phase is high (`ST_HI`), `xfer_valid` is 0, `db_oe` is 0 and `core_rst_n` is 1.
- R2: Enable style (`style_sep`=0) write: while `ctl_dir_wrn` is 0, the falling edge of `ctl_stb_rdn` (E) produces one record. In that record `xfer_read`=0, `xfer_rs` equals `rs_in` (0 instruction, 1 data) and `xfer_data` equals `db_in`, all as they were before the edge.
- R3: Enable style read: while `ctl_dir_wrn` is 1 and E is high, `db_oe`=1 and `db_out`=`rd_data`. The falling edge of E then produces one record with `xfer_read`=1.
- R4: Split style (`style_sep`=1) write: a rising edge of `ctl_dir_wrn` (write strobe, active low) produces one record with `xfer_read`=0 and the byte and `rs_in` held during the strobe.
- R5: Split style read: while `ctl_stb_rdn` (read strobe, active low) is low, `db_oe`=1 and `db_out`=`rd_data`. Its rising edge produces one record with `xfer_read`=1.
- R6: With `dl_wide`=0, a write takes two strobes: the first carries bits 7:4 of the byte on `db_in[7:4]`, the second carries bits 3:0 on `db_in[7:4]`. `db_in[3:0]` is ignored. Exactly one record follows, after the second strobe.
- R7: With `dl_wide`=0, a read takes two strobes: during the first, `db_out[7:4]`=`rd_data[7:4]`, and during the second, `db_out[7:4]`=`rd_data[3:0]`. One read record follows, after the second strobe.
- R8: A change of `dl_wide` returns the phase to high, so the next nibble starts a new byte. The phase is never low while the registered width is 8-bit.
- R9: While `ext_rst_n` is low (after two clocks of synchronization), `core_rst_n`=0, no record is produced and the phase is cleared. After release, the next nibble is a high nibble.
- R10: `xfer_valid` is a one-clock pulse, one per completed transfer.
- R11: `db_oe` is 0 when no read strobe is active, including during write strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| style_sep | input | 1 | Strap: 0 enable style, 1 split read/write strobes |
| ext_rst_n | input | 1 | Host external reset, active low |
| rs_in | input | 1 | Register select: 0 instruction, 1 data |
| ctl_dir_wrn | input | 1 | Read/write level (enable style) or write strobe, active low (split style) |
| ctl_stb_rdn | input | 1 | Enable strobe (enable style) or read strobe, active low (split style) |
| db_in | input | 8 | Data bus input from host |
| db_out | output | 8 | Data bus value driven during reads |
| db_oe | output | 1 | Data bus output enable |
| dl_wide | input | 1 | Width bit from core: 1 8-bit, 0 4-bit |
| rd_data | input | 8 | Read byte supplied by the core |
| xfer_valid | output | 1 | One-clock transfer pulse |
| xfer_rs | output | 1 | Register select of the transfer |
| xfer_read | output | 1 | 1 for a read transfer, 0 for a write |
| xfer_data | output | 8 | Assembled write byte (0 on reads) |
| core_rst_n | output | 1 | Synchronized external reset to the core |

## Verification
The assertions watch four properties on every clock:
- the transfer pulse never lasts two clocks;
- nothing is emitted while external reset holds the machine;
- the low-nibble phase never coexists with 8-bit width;
- a width change with no coincident transfer returns the phase to high.

Only the bench scenarios can show the rest. That covers the byte values reassembled from nibbles, the nibble placed on the bus during each half of a 4-bit read, the correct edge chosen in each strobe style, and the output enable staying off through write strobes. The bench checks these by comparing every record against a queue of predicted transfers.

// File: rtl/hostif_pkg.sv
package hostif_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2
    } phase_e;
endpackage

// File: rtl/hostif_sync.sv
module hostif_sync #(
    parameter int W     = 1,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] idle_val,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= idle_val;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[DEPTH-1];
endmodule

// File: rtl/hostif_nibble_fsm.sv
module hostif_nibble_fsm
    import hostif_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          dl_wide,
    input  logic          ev_valid,
    input  logic          ev_read,
    input  logic          ev_rs,
    input  logic [DW-1:0] ev_data,
    output logic          lo_phase,
    output logic          xfer_valid,
    output logic          xfer_rs,
    output logic          xfer_read,
    output logic [DW-1:0] xfer_data
);
    localparam int NW = DW / 2;

    phase_e        state, eff, nxt;
    logic          dl_q;
    logic          dl_chg;
    logic [NW-1:0] hi_nib;

    assign dl_chg = (dl_wide != dl_q);
    assign eff    = (dl_chg && state == ST_LO) ? ST_HI : state;

    always_comb begin
        nxt = eff;
        unique case (eff)
            ST_HOLD: nxt = hold ? ST_HOLD : ST_HI;
            ST_HI:   nxt = hold ? ST_HOLD : ((ev_valid && !dl_wide) ? ST_LO : ST_HI);
            ST_LO:   nxt = hold ? ST_HOLD : (ev_valid ? ST_HI : ST_LO);
            default: nxt = ST_HI;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HI;
            dl_q  <= 1'b1;
        end else begin
            state <= nxt;
            dl_q  <= dl_wide;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_valid <= 1'b0;
            xfer_rs    <= 1'b0;
            xfer_read  <= 1'b0;
            xfer_data  <= '0;
            hi_nib     <= '0;
        end else begin
            xfer_valid <= 1'b0;
            if (!hold && ev_valid && eff != ST_HOLD) begin
                if (eff == ST_HI && !dl_wide) begin
                    hi_nib <= ev_data[DW-1:NW];
                end else begin
                    xfer_valid <= 1'b1;
                    xfer_rs    <= ev_rs;
                    xfer_read  <= ev_read;
                    if (ev_read)
                        xfer_data <= '0;
                    else if (eff == ST_LO)
                        xfer_data <= {hi_nib, ev_data[DW-1:NW]};
                    else
                        xfer_data <= ev_data;
                end
            end
        end
    end

    assign lo_phase = (state == ST_LO);

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> !xfer_valid);
    p_hold_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !xfer_valid);
    p_wide_no_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LO) |-> !dl_q);
    p_width_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_chg && !ev_valid && !hold) |=> (state == ST_HI));
endmodule

// File: rtl/hostif_pbus.sv
module hostif_pbus
    import hostif_pkg::*;
#(
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          style_sep,
    input  logic          ext_rst_n,
    input  logic          rs_in,
    input  logic          ctl_dir_wrn,
    input  logic          ctl_stb_rdn,
    input  logic [DW-1:0] db_in,
    output logic [DW-1:0] db_out,
    output logic          db_oe,
    input  logic          dl_wide,
    input  logic [DW-1:0] rd_data,
    output logic          xfer_valid,
    output logic          xfer_rs,
    output logic          xfer_read,
    output logic [DW-1:0] xfer_data,
    output logic          core_rst_n
);
    localparam int NW = DW / 2;

    logic [1:0]    ctl_now, ctl_prev;
    logic [DW:0]   dat_al;
    logic [1:0]    xrst;
    logic          dir_now, stb_now, dir_prev, stb_prev;
    logic          ev_wr, ev_rd, rd_active, lo_phase;

    hostif_sync #(.W(2), .DEPTH(SYNC)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .idle_val({style_sep, style_sep}),
        .din({ctl_dir_wrn, ctl_stb_rdn}), .q(ctl_now));

    // one stage deeper so the bus value is the one seen before the edge
    hostif_sync #(.W(DW + 1), .DEPTH(SYNC + 1)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .idle_val('0),
        .din({rs_in, db_in}), .q(dat_al));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_prev <= {style_sep, style_sep};
            xrst     <= 2'b11;
        end else begin
            ctl_prev <= ctl_now;
            xrst     <= {xrst[0], ext_rst_n};
        end
    end

    assign {dir_now, stb_now}   = ctl_now;
    assign {dir_prev, stb_prev} = ctl_prev;
    assign core_rst_n = xrst[1];

    always_comb begin
        if (style_sep) begin
            ev_wr     = dir_now && !dir_prev;
            ev_rd     = stb_now && !stb_prev && !ev_wr;
            rd_active = !stb_now;
        end else begin
            ev_wr     = !stb_now && stb_prev && !dir_prev;
            ev_rd     = !stb_now && stb_prev && dir_prev;
            rd_active = stb_now && dir_now;
        end
    end

    hostif_nibble_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hold(!core_rst_n), .dl_wide(dl_wide),
        .ev_valid(ev_wr || ev_rd), .ev_read(ev_rd), .ev_rs(dat_al[DW]),
        .ev_data(dat_al[DW-1:0]), .lo_phase(lo_phase),
        .xfer_valid(xfer_valid), .xfer_rs(xfer_rs), .xfer_read(xfer_read),
        .xfer_data(xfer_data));

    assign db_oe  = rd_active && core_rst_n;
    assign db_out = lo_phase ? {rd_data[NW-1:0], {NW{1'b0}}} : rd_data;
endmodule

// File: tb/tb_hostif_pbus.sv
module tb_hostif_pbus;
    logic clk = 0, rst_n = 0, style_sep = 0, ext_rst_n = 1, rs_in = 0;
    logic ctl_dir_wrn = 0, ctl_stb_rdn = 0, dl_wide = 1;
    logic [7:0] db_in = 0, rd_data = 0, db_out, xfer_data;
    logic db_oe, xfer_valid, xfer_rs, xfer_read, core_rst_n;
    int total = 0, bad = 0;
    logic [9:0] exp_q[$];

    always #5 clk = ~clk;

    hostif_pbus dut (.clk(clk), .rst_n(rst_n), .style_sep(style_sep), .ext_rst_n(ext_rst_n),
        .rs_in(rs_in), .ctl_dir_wrn(ctl_dir_wrn), .ctl_stb_rdn(ctl_stb_rdn), .db_in(db_in),
        .db_out(db_out), .db_oe(db_oe), .dl_wide(dl_wide), .rd_data(rd_data),
        .xfer_valid(xfer_valid), .xfer_rs(xfer_rs), .xfer_read(xfer_read),
        .xfer_data(xfer_data), .core_rst_n(core_rst_n));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference: every clock, a pulse must match the oldest predicted record
    always @(negedge clk) begin
        if (rst_n && xfer_valid === 1'b1) begin
            if (exp_q.size() == 0) chk("R10 unexpected record", 1, 0);
            else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk("R2/R4 record rs", {31'd0, xfer_rs}, {31'd0, e[9]});
                chk("R2/R3 record dir", {31'd0, xfer_read}, {31'd0, e[8]});
                if (!e[8]) chk("R6 record byte", {24'd0, xfer_data}, {24'd0, e[7:0]});
            end
        end
    end

    task automatic pulse_wr(input logic rs, input logic [7:0] bus, input bit last, input bit push, input logic [7:0] full);
        rs_in = rs; db_in = bus;
        if (!style_sep) ctl_dir_wrn = 0;
        idle(3);
        if (!style_sep) ctl_stb_rdn = 1; else ctl_dir_wrn = 0;
        idle(4);
        chk("R11 oe low during write", {31'd0, db_oe}, 0);
        if (!style_sep) ctl_stb_rdn = 0; else ctl_dir_wrn = 1;
        if (last && push) exp_q.push_back({rs, 1'b0, full});
        idle(6);
    endtask

    task automatic host_write(input logic rs, input logic [7:0] v, input bit push);
        if (dl_wide) pulse_wr(rs, v, 1, push, v);
        else begin
            pulse_wr(rs, {v[7:4], 4'h5}, 0, push, v);
            pulse_wr(rs, {v[3:0], 4'hA}, 1, push, v);
        end
    endtask

    task automatic pulse_rd(input logic rs, input logic [7:0] exp, input logic [7:0] mask, input bit last, input string tag);
        rs_in = rs;
        if (!style_sep) ctl_dir_wrn = 1;
        idle(3);
        if (!style_sep) ctl_stb_rdn = 1; else ctl_stb_rdn = 0;
        idle(4);
        chk({tag, " oe during read"}, {31'd0, db_oe}, 1);
        chk({tag, " read bus"}, {24'd0, db_out & mask}, {24'd0, exp & mask});
        if (!style_sep) ctl_stb_rdn = 0; else ctl_stb_rdn = 1;
        if (last) exp_q.push_back({rs, 1'b1, 8'h00});
        idle(4);
        chk("R11 oe released", {31'd0, db_oe}, 0);
        if (!style_sep) ctl_dir_wrn = 0;
        idle(2);
    endtask

    task automatic host_read(input logic rs, input logic [7:0] v);
        rd_data = v;
        if (dl_wide) pulse_rd(rs, v, 8'hFF, 1, style_sep ? "R5" : "R3");
        else begin
            pulse_rd(rs, v, 8'hF0, 0, "R7 high");
            pulse_rd(rs, {v[3:0], 4'h0}, 8'hF0, 1, "R7 low");
        end
    endtask

    task automatic drained(input string tag);
        idle(4);
        chk({tag, " record delivered"}, exp_q.size(), 0);
    endtask

    task automatic restart(input logic sep);
        rst_n = 0; style_sep = sep;
        ctl_dir_wrn = sep; ctl_stb_rdn = sep; dl_wide = 1;
        idle(4); rst_n = 1; idle(3);
    endtask

    initial begin
        #2_000_000;
        chk("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        restart(0);
        // R1 reset state
        chk("R1 xfer_valid", {31'd0, xfer_valid}, 0);
        chk("R1 db_oe", {31'd0, db_oe}, 0);
        chk("R1 core_rst_n", {31'd0, core_rst_n}, 1);
        // R2 enable-style writes, instruction and data
        host_write(0, 8'h38, 1); drained("R2");
        host_write(1, 8'h41, 1); drained("R2");
        // R3 enable-style reads
        host_read(1, 8'h5A); drained("R3");
        host_read(0, 8'h27); drained("R3");
        // R6 / R7 nibble mode
        dl_wide = 0; idle(3);
        host_write(1, 8'hC7, 1); drained("R6");
        host_write(0, 8'h0F, 1); drained("R6");
        host_read(1, 8'h9E); drained("R7");
        // R8 width change clears phase
        pulse_wr(1, 8'hA0, 0, 0, 8'h00);
        dl_wide = 1; idle(3); dl_wide = 0; idle(3);
        host_write(1, 8'h3C, 1); drained("R8");
        pulse_wr(1, 8'hB0, 0, 0, 8'h00);
        dl_wide = 1; idle(3);
        host_write(0, 8'h81, 1); drained("R8 wide after half");
        // R9 external reset
        dl_wide = 0; idle(3);
        pulse_wr(1, 8'hE0, 0, 0, 8'h00);
        ext_rst_n = 0; idle(4);
        chk("R9 core_rst_n low", {31'd0, core_rst_n}, 0);
        host_write(1, 8'h77, 0);
        chk("R9 no record in hold", exp_q.size(), 0);
        ext_rst_n = 1; idle(4);
        chk("R9 core_rst_n released", {31'd0, core_rst_n}, 1);
        host_write(1, 8'h56, 1); drained("R9 phase cleared");
        // split style
        restart(1);
        chk("R1 split idle oe", {31'd0, db_oe}, 0);
        host_write(0, 8'h01, 1); drained("R4");
        host_write(1, 8'hD3, 1); drained("R4");
        host_read(1, 8'h6B); drained("R5");
        dl_wide = 0; idle(3);
        host_write(1, 8'h4E, 1); drained("R6 split");
        host_read(0, 8'hA5); drained("R7 split");
        idle(10);
        chk("R10 no stray records", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule